// File: doc/BRIEF.md
# Banked Link Format and Bank Selector Register

This block holds two byte-wide control registers that live behind a single CPU address in a banked serial-port register map. One is the link format register, which sets character width, stop bits, parity and break for the serial engines. The other is the bank selector, which chooses the register bank that later accesses reach. Bit 7 of a written byte steers the write. When it is clear, both registers take the byte. When it is set, only the bank selector takes it. Software can therefore move between banks without disturbing the line format.

A read at the shared address returns the bank selector. The link format register is read back through a shadow offset that is only visible while bank 3 is selected. The CPU side is a simple synchronous bus with address, write and read strobes and byte-wide data. Read data is registered and holds its value between read strobes. The block drives the current bank number and the decoded format fields to the serial logic.

Top module: `link_bank_regs`

## Requirements
- R1: After reset, both registers are 0. Bank is 0, data_bits is 5, stop_cfg is 0, par_mode is 0, set_break is 0 and rd_data is 0.
- R2: A write at SHARED_ADDR (default 3) with data bit 7 equal to 0 stores the byte in both the link format register and the bank selector.
- R3: A write at SHARED_ADDR with data bit 7 equal to 1 stores the byte in the bank selector only. All link format outputs keep their values.
- R4: A read at SHARED_ADDR returns the bank selector byte on rd_data one clock after the read strobe.
- R5: While the bank output equals 3, a read at SHADOW_ADDR (default 7) returns the link format byte one clock after the strobe.
- R6: The bank output is 0 when bank selector bit 7 is 0. Otherwise it is bank selector bits 1..0.
- R7: Any other read returns 0. This includes SHADOW_ADDR while the bank is not 3.
- R8: data_bits equals 5 plus link format bits 1..0 (5, 6, 7 or 8).
- R9: stop_cfg is 0 (one stop bit) when format bit 2 is 0. It is 1 (one and a half) when bit 2 is 1 and bits 1..0 are 00. It is 2 (two) when bit 2 is 1 with any other width.
- R10: par_mode is derived from format bits 5 (stick), 4 (even) and 3 (enable). It is 0 (none) when enable is 0, 1 (odd), 2 (even), 3 (forced 1) for stick=1/even=0, and 4 (forced 0) for stick=1/even=1. set_break follows format bit 6.
- R11: Writes at any address other than SHARED_ADDR change no register. Reads change no register.
- R12: rd_data changes only on a clock edge where rd_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| bank | output | BANK_W | Selected bank number |
| data_bits | output | 4 | Character width, 5 to 8 |
| stop_cfg | output | 2 | Stop-bit setting code |
| par_mode | output | 3 | Parity setting code |
| set_break | output | 1 | Force break on the line |

## Verification
The table alternates writes with bit 7 clear and bit 7 set, so that a write that wrongly reaches the format register shows up immediately in the decoded fields. Each format byte is chosen to reach a different width, stop-bit and parity code. Every bank-select row is followed by a shared read and, in bank 3, a shadow read. Together these separate a swapped read mux from a swapped write path. Directed cases cover the shadow offset outside bank 3, an unmapped offset, writes to other offsets, an idle cycle with no read strobe, and a reset in mid-run.

// File: rtl/link_bank_regs.sv
module link_bank_regs #(
  parameter int ADDR_W      = 3,
  parameter int BANK_W      = 2,
  parameter int SHARED_ADDR = 3,
  parameter int SHADOW_ADDR = 7,
  parameter int SHADOW_BANK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [BANK_W-1:0] bank,
  output logic [3:0]        data_bits,
  output logic [1:0]        stop_cfg,
  output logic [2:0]        par_mode,
  output logic              set_break
);
  localparam logic [ADDR_W-1:0] A_SHARED = ADDR_W'(SHARED_ADDR);
  localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(SHADOW_ADDR);
  localparam logic [BANK_W-1:0] B_SHADOW = BANK_W'(SHADOW_BANK);

  logic [7:0] lcr_q, bsr_q, rd_next;
  logic       hit_shared, fmt_we;

  assign hit_shared = (addr == A_SHARED);
  assign fmt_we     = wr_en && hit_shared && !wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsr_q <= '0;
      lcr_q <= '0;
    end else begin
      if (wr_en && hit_shared) bsr_q <= wr_data;
      if (fmt_we)              lcr_q <= wr_data;
    end
  end

  assign bank = bsr_q[7] ? bsr_q[BANK_W-1:0] : '0;

  always_comb begin
    if (hit_shared)                              rd_next = bsr_q;
    else if (addr == A_SHADOW && bank == B_SHADOW) rd_next = lcr_q;
    else                                         rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign data_bits = 4'd5 + {2'b00, lcr_q[1:0]};
  assign stop_cfg  = !lcr_q[2] ? 2'd0 : (lcr_q[1:0] == 2'b00) ? 2'd1 : 2'd2;
  assign set_break = lcr_q[6];

  always_comb begin
    unique case ({lcr_q[3], lcr_q[5], lcr_q[4]})
      3'b100:  par_mode = 3'd1;
      3'b101:  par_mode = 3'd2;
      3'b110:  par_mode = 3'd3;
      3'b111:  par_mode = 3'd4;
      default: par_mode = 3'd0;
    endcase
  end
endmodule

module link_bank_regs_chk #(
  parameter int ADDR_W      = 3,
  parameter int BANK_W      = 2,
  parameter int SHARED_ADDR = 3,
  parameter int SHADOW_ADDR = 7,
  parameter int SHADOW_BANK = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic [BANK_W-1:0] bank,
  input logic [3:0]        data_bits,
  input logic [1:0]        stop_cfg,
  input logic [2:0]        par_mode,
  input logic              set_break,
  input logic [7:0]        bsr_q
);
  localparam logic [ADDR_W-1:0] A_SHARED = ADDR_W'(SHARED_ADDR);
  localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(SHADOW_ADDR);
  localparam logic [BANK_W-1:0] B_SHADOW = BANK_W'(SHADOW_BANK);

  AST_FMT_HELD_ON_BANKSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SHARED && wr_data[7]) |=> $stable({data_bits, stop_cfg, par_mode, set_break})); // R3
  AST_FMT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SHARED && !wr_data[7]) |=> (set_break == $past(wr_data[6]) && bank == '0)); // R2
  AST_SHARED_READ_BSR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SHARED) |=> (rd_data == $past(bsr_q))); // R4
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != A_SHARED && !(addr == A_SHADOW && bank == B_SHADOW)) |=> (rd_data == 8'h00)); // R7
  AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_SHARED) |=> $stable({bank, data_bits, stop_cfg, par_mode, set_break})); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rd_data)); // R12
endmodule

bind link_bank_regs link_bank_regs_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SHARED_ADDR(SHARED_ADDR),
  .SHADOW_ADDR(SHADOW_ADDR), .SHADOW_BANK(SHADOW_BANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .bank(bank), .data_bits(data_bits),
  .stop_cfg(stop_cfg), .par_mode(par_mode), .set_break(set_break), .bsr_q(bsr_q)
);

// File: tb/tb_link_bank_regs.sv
module tb_link_bank_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {write byte, bank, data_bits, stop_cfg, par_mode, set_break}
  localparam logic [19:0] VEC [NV] = '{
    {8'h03, 2'd0, 4'd8, 2'd0, 3'd0, 1'b0},
    {8'h83, 2'd3, 4'd8, 2'd0, 3'd0, 1'b0},
    {8'h0C, 2'd0, 4'd5, 2'd1, 3'd1, 1'b0},
    {8'h81, 2'd1, 4'd5, 2'd1, 3'd1, 1'b0},
    {8'h1D, 2'd0, 4'd6, 2'd2, 3'd2, 1'b0},
    {8'h2A, 2'd0, 4'd7, 2'd0, 3'd3, 1'b0},
    {8'h7F, 2'd0, 4'd8, 2'd2, 3'd4, 1'b1},
    {8'hFE, 2'd2, 4'd8, 2'd2, 3'd4, 1'b1},
    {8'h30, 2'd0, 4'd5, 2'd0, 3'd0, 1'b0},
    {8'h83, 2'd3, 4'd5, 2'd0, 3'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] bank, stop_cfg;
  logic [3:0] data_bits;
  logic [2:0] par_mode;
  logic set_break;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] lcr_m, rv;

  link_bank_regs dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bank(bank), .data_bits(data_bits), .stop_cfg(stop_cfg),
    .par_mode(par_mode), .set_break(set_break));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic check_fmt(input string req, input logic [19:0] v);
    check({req, " bank R6"}, {6'd0, bank}, {6'd0, v[11:10]});
    check({req, " bits R8"}, {4'd0, data_bits}, {4'd0, v[9:6]});
    check({req, " stop R9"}, {6'd0, stop_cfg}, {6'd0, v[5:4]});
    check({req, " parity R10"}, {5'd0, par_mode}, {5'd0, v[3:1]});
    check({req, " break R10"}, {7'd0, set_break}, {7'd0, v[0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 8'h00);
    check_fmt("R1 reset", 20'h00140);
    @(negedge clk); rst_n = 1'b1;
    lcr_m = 8'h00;

    for (int i = 0; i < NV; i++) begin
      wr(3'd3, VEC[i][19:12]);
      if (!VEC[i][19]) lcr_m = VEC[i][19:12];
      check_fmt(VEC[i][19] ? "R3 banksel" : "R2 format", VEC[i]);
      rd(3'd3, rv);
      check("R4 shared read", rv, VEC[i][19:12]);
      if (VEC[i][11:10] == 2'd3) begin
        rd(3'd7, rv);
        check("R5 shadow read", rv, lcr_m);
      end
    end

    wr(3'd3, 8'h5D);
    wr(3'd3, 8'h82);
    rd(3'd7, rv);
    check("R7 shadow outside bank 3", rv, 8'h00);
    rd(3'd5, rv);
    check("R7 unmapped read", rv, 8'h00);
    wr(3'd3, 8'h83);
    rd(3'd7, rv);
    check("R5 shadow after banksel", rv, 8'h5D);
    wr(3'd7, 8'h00);
    wr(3'd1, 8'h00);
    check_fmt("R11 other writes", {8'h00, 2'd3, 4'd6, 2'd2, 3'd2, 1'b1});
    rd(3'd3, rv);
    check("R11 bsr untouched", rv, 8'h83);
    rd(3'd7, rv);
    check("R11 lcr untouched", rv, 8'h5D);
    @(negedge clk); addr = 3'd5;
    @(negedge clk);
    check("R12 hold without strobe", rd_data, 8'h5D);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset rd_data", rd_data, 8'h00);
    check_fmt("R1 mid reset", 20'h00140);
    rst_n = 1'b1;
    rd(3'd3, rv);
    check("R1 bsr after reset", rv, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule